// File: doc/BRIEF.md
# SDRAM Power-Up Command Sequencer

This block takes an SDRAM array from power-up to normal operation. A start pulse launches a fixed series of controller commands. Each command appears as a code on a command bus together with a strobe. It counts as issued only on a cycle where the downstream side also raises its accept line. One accepted strobe is one command, in the same way that each dummy access would carry the currently selected command to the memories.

The series has three parts. It opens with a no-operation command, then holds off for a programmable number of clock cycles that stands for the power-up settling time. After that it issues precharge-all, two auto-refreshes, a mode-register load, eight further auto-refreshes and finally the normal-mode command. When start is accepted, the block also loads its static setup outputs: the slowest timing setting, the largest bank ending address and the widest bank geometry. The buffer and error-correction enables stay off. A busy flag covers the whole run, and a one-cycle done pulse marks its end.

Top module: `sdram_init_seq`

## Requirements
- R1: After reset, busy, done, strobe, both feature enables and all three setup outputs are low, and the command code reads 0.
- R2: A start pulse while idle makes busy and strobe high on the next cycle, with command code 1 (no-operation).
- R3: The accepted commands, in order, carry the codes 1, 2, 4, 4, 3, 4, 4, 4, 4, 4, 4, 4, 4, 0: no-op 1, precharge-all 2, auto-refresh 4, mode-register load 3, normal mode 0. That is 14 transfers per run.
- R4: A command transfers on a rising edge where strobe and accept are both high. While the strobe is high without accept, the strobe stays high and the code does not change.
- R5: After the no-op transfers, the strobe stays low for exactly WAIT_CYC cycles. The precharge strobe then rises, so with accept held high the precharge transfers WAIT_CYC+1 cycles after the no-op.
- R6: From the cycle after an accepted start, the timing output is 0x1E, the bank ending address output is 0xFF and the bank configuration output is 0xBBBB.
- R7: The write/read-ahead buffer enable and the ECC enable outputs stay low throughout.
- R8: In the cycle after the normal-mode transfer, busy is low and done is high. Done is high for that single cycle only.
- R9: A start pulse while busy is ignored: the run keeps its 14-transfer log and produces a single done pulse.
- R10: A start after done runs the complete series again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Launch the initialisation series |
| cmd_ack_i | input | 1 | Downstream accepts the strobed command |
| cmd_code_o | output | 3 | Current command code |
| cmd_stb_o | output | 1 | Command strobe (dummy access) |
| busy_o | output | 1 | Series in progress |
| done_o | output | 1 | One-cycle completion pulse |
| timing_o | output | 8 | Timing setup value |
| bank_end_o | output | 8 | Bank ending address, top byte |
| bank_cfg_o | output | 16 | Bank geometry setup |
| buf_en_o | output | 1 | Write buffer / read-ahead enable |
| ecc_en_o | output | 1 | ECC enable |

## Verification
Strobe, code and setup outputs appear one cycle after the edge that samples start. Each transfer happens at the edge where accept is seen together with the strobe. The precharge strobe rises WAIT_CYC cycles after the no-op transfer, and done follows the normal-mode transfer by one cycle. The bench drives inputs on falling edges, logs transfers with a cycle stamp on rising edges, and reads the outputs on falling edges. Every comparison therefore falls in a cycle whose register count is known, both for an accept held high and for an accept that arrives only every third cycle.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;
  localparam int CMD_W = 3;

  typedef enum logic [CMD_W-1:0] {
    CMD_NORMAL    = 3'd0,
    CMD_NOP       = 3'd1,
    CMD_PRECHARGE = 3'd2,
    CMD_LOADMODE  = 3'd3,
    CMD_REFRESH   = 3'd4
  } sdram_cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } seq_state_e;

  localparam logic [7:0]  INIT_TIMING   = 8'h1E;
  localparam logic [7:0]  INIT_BANK_END = 8'hFF;
  localparam logic [15:0] INIT_BANK_CFG = 16'hBBBB;
endpackage

// File: rtl/sdram_init_steps.sv
module sdram_init_steps
  import sdram_init_pkg::*;
#(
  parameter int PRE_REF  = 2,
  parameter int POST_REF = 8,
  localparam int NSTEP   = PRE_REF + POST_REF + 4,
  localparam int SW      = $clog2(NSTEP)
) (
  input  logic [SW-1:0] step_i,
  output sdram_cmd_e    code_o,
  output logic          is_nop_o,
  output logic          is_last_o
);
  localparam logic [SW-1:0] S_PRE    = SW'(1);
  localparam logic [SW-1:0] S_LMR    = SW'(2 + PRE_REF);
  localparam logic [SW-1:0] S_NORMAL = SW'(NSTEP - 1);

  always_comb begin
    if (step_i == '0)             code_o = CMD_NOP;
    else if (step_i == S_PRE)     code_o = CMD_PRECHARGE;
    else if (step_i < S_LMR)      code_o = CMD_REFRESH;
    else if (step_i == S_LMR)     code_o = CMD_LOADMODE;
    else if (step_i < S_NORMAL)   code_o = CMD_REFRESH;
    else                          code_o = CMD_NORMAL;
  end

  assign is_nop_o  = (step_i == '0);
  assign is_last_o = (step_i == S_NORMAL);
endmodule

// File: rtl/sdram_init_timer.sv
module sdram_init_timer #(
  parameter int WAIT_CYC = 20000,
  localparam int CW      = $clog2(WAIT_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  output logic expired_o
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          run_q, run_d;

  always_comb begin
    cnt_d = cnt_q;
    run_d = run_q;
    if (load_i) begin
      cnt_d = CW'(WAIT_CYC - 1);
      run_d = 1'b1;
    end else if (run_q) begin
      if (cnt_q == '0) run_d = 1'b0;
      else             cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      run_q <= run_d;
    end
  end

  assign expired_o = run_q && (cnt_q == '0);
endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdram_init_pkg::*;
#(
  parameter int WAIT_CYC = 20000,
  parameter int PRE_REF  = 2,
  parameter int POST_REF = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic        cmd_ack_i,
  output logic [2:0]  cmd_code_o,
  output logic        cmd_stb_o,
  output logic        busy_o,
  output logic        done_o,
  output logic [7:0]  timing_o,
  output logic [7:0]  bank_end_o,
  output logic [15:0] bank_cfg_o,
  output logic        buf_en_o,
  output logic        ecc_en_o
);
  localparam int NSTEP = PRE_REF + POST_REF + 4;
  localparam int SW    = $clog2(NSTEP);

  seq_state_e     state_q, state_d;
  logic [SW-1:0]  step_q, step_d;
  logic           done_q, done_d;
  logic           tmr_load, tmr_expired, cfg_load;
  sdram_cmd_e     step_code;
  logic           step_nop, step_last;
  logic [7:0]     timing_q, bank_end_q;
  logic [15:0]    bank_cfg_q;
  logic           buf_en_q, ecc_en_q;

  sdram_init_steps #(.PRE_REF(PRE_REF), .POST_REF(POST_REF)) u_steps (
    .step_i    (step_q),
    .code_o    (step_code),
    .is_nop_o  (step_nop),
    .is_last_o (step_last)
  );

  sdram_init_timer #(.WAIT_CYC(WAIT_CYC)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (tmr_load),
    .expired_o (tmr_expired)
  );

  always_comb begin
    state_d  = state_q;
    step_d   = step_q;
    done_d   = 1'b0;
    tmr_load = 1'b0;
    cfg_load = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        state_d  = ST_ISSUE;
        step_d   = '0;
        cfg_load = 1'b1;
      end
      ST_ISSUE: if (cmd_ack_i) begin
        if (step_last) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end else if (step_nop) begin
          state_d  = ST_WAIT;
          tmr_load = 1'b1;
        end else begin
          step_d = step_q + 1'b1;
        end
      end
      ST_WAIT: if (tmr_expired) begin
        state_d = ST_ISSUE;
        step_d  = step_q + 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      step_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      step_q  <= step_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      timing_q   <= '0;
      bank_end_q <= '0;
      bank_cfg_q <= '0;
      buf_en_q   <= 1'b0;
      ecc_en_q   <= 1'b0;
    end else if (cfg_load) begin
      timing_q   <= INIT_TIMING;
      bank_end_q <= INIT_BANK_END;
      bank_cfg_q <= INIT_BANK_CFG;
      buf_en_q   <= 1'b0;
      ecc_en_q   <= 1'b0;
    end
  end

  assign cmd_stb_o  = (state_q == ST_ISSUE);
  assign cmd_code_o = cmd_stb_o ? step_code : CMD_NORMAL;
  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = done_q;
  assign timing_o   = timing_q;
  assign bank_end_o = bank_end_q;
  assign bank_cfg_o = bank_cfg_q;
  assign buf_en_o   = buf_en_q;
  assign ecc_en_o   = ecc_en_q;
endmodule

// File: rtl/sdram_init_seq_chk.sv
module sdram_init_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_ack_i,
  input logic [2:0]  cmd_code_o,
  input logic        cmd_stb_o,
  input logic        busy_o,
  input logic        done_o,
  input logic [7:0]  timing_o,
  input logic [7:0]  bank_end_o,
  input logic [15:0] bank_cfg_o,
  input logic        buf_en_o,
  input logic        ecc_en_o
);
  p_first_nop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> cmd_stb_o && cmd_code_o == 3'd1);

  p_hold_cmd_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stb_o && !cmd_ack_i |=> cmd_stb_o && $stable(cmd_code_o));

  p_setup_vals_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> timing_o == 8'h1E && bank_end_o == 8'hFF && bank_cfg_o == 16'hBBBB);

  p_feat_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !buf_en_o && !ecc_en_o);

  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o && !cmd_stb_o);

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_stb_in_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stb_o |-> busy_o);
endmodule

bind sdram_init_seq sdram_init_seq_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_ack_i  (cmd_ack_i),
  .cmd_code_o (cmd_code_o),
  .cmd_stb_o  (cmd_stb_o),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .timing_o   (timing_o),
  .bank_end_o (bank_end_o),
  .bank_cfg_o (bank_cfg_o),
  .buf_en_o   (buf_en_o),
  .ecc_en_o   (ecc_en_o)
);

// File: tb/sdram_init_seq_tb.sv
module sdram_init_seq_tb;
  localparam int WAIT = 64;
  localparam int NCMD = 14;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic cmd_ack_i = 1'b0;
  logic [2:0]  cmd_code_o;
  logic        cmd_stb_o, busy_o, done_o, buf_en_o, ecc_en_o;
  logic [7:0]  timing_o, bank_end_o;
  logic [15:0] bank_cfg_o;

  always #2.5 clk = ~clk;

  sdram_init_seq #(.WAIT_CYC(WAIT)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .cmd_ack_i(cmd_ack_i),
    .cmd_code_o(cmd_code_o), .cmd_stb_o(cmd_stb_o), .busy_o(busy_o),
    .done_o(done_o), .timing_o(timing_o), .bank_end_o(bank_end_o),
    .bank_cfg_o(bank_cfg_o), .buf_en_o(buf_en_o), .ecc_en_o(ecc_en_o)
  );

  int vec = 0;
  int bad = 0;

  // transfer log written only by this monitor
  int cyc = 0;
  int nlog = 0;
  int log_code [256];
  int log_cyc  [256];
  int done_cnt = 0;
  int hold_err = 0;
  int feat_err = 0;
  logic hold_pend = 1'b0;
  logic [2:0] hold_code = '0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst_n) begin
      if (hold_pend && (!cmd_stb_o || cmd_code_o != hold_code)) hold_err <= hold_err + 1;
      hold_pend <= cmd_stb_o && !cmd_ack_i;
      hold_code <= cmd_code_o;
      if (buf_en_o || ecc_en_o) feat_err <= feat_err + 1;
      if (done_o) done_cnt <= done_cnt + 1;
      if (cmd_stb_o && cmd_ack_i && nlog < 256) begin
        log_code[nlog] <= int'(cmd_code_o);
        log_cyc[nlog]  <= cyc;
        nlog <= nlog + 1;
      end
    end
  end

  function automatic int exp_code(int i);
    if (i == 0) return 1;
    if (i == 1) return 2;
    if (i == 4) return 3;
    if (i == NCMD - 1) return 0;
    return 4;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vec++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // ack_mode 0: always accept; 1: accept every third cycle
  // stray: pulse start while busy
  task automatic run_seq(input int ack_mode, input bit stray, input string tag);
    int base, dbase, hbase, steps;
    bit seen_done;
    base  = nlog;
    dbase = done_cnt;
    hbase = hold_err;
    @(negedge clk);
    start_i   = 1'b1;
    cmd_ack_i = (ack_mode == 0);
    @(negedge clk);
    start_i = 1'b0;
    check(busy_o && cmd_stb_o && cmd_code_o == 3'd1, {"R2 ", tag}, int'(cmd_code_o), 1);
    check(timing_o == 8'h1E && bank_end_o == 8'hFF, {"R6 timing/end ", tag},
          int'({timing_o, bank_end_o}), 16'h1EFF);
    check(bank_cfg_o == 16'hBBBB, {"R6 cfg ", tag}, int'(bank_cfg_o), 16'hBBBB);
    seen_done = 1'b0;
    steps = 0;
    while (!seen_done && steps < 2000) begin
      cmd_ack_i = (ack_mode == 0) ? 1'b1 : ((cyc % 3) == 0);
      if (stray && steps == 10) start_i = 1'b1;
      if (stray && steps == 30) start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      steps++;
      if (done_o) begin
        seen_done = 1'b1;
        check(!busy_o, {"R8 busy low at done ", tag}, int'(busy_o), 0);
        check(log_cyc[nlog-1] == cyc - 1, {"R8 done timing ", tag}, log_cyc[nlog-1], cyc - 1);
      end
    end
    cmd_ack_i = 1'b0;
    check(seen_done, {"R8 done seen ", tag}, int'(seen_done), 1);
    @(negedge clk);
    check(!done_o && !busy_o, {"R8 done one cycle ", tag}, int'(done_o), 0);
    repeat (5) @(negedge clk);
    check(nlog - base == NCMD, {"R3 transfer count ", tag}, nlog - base, NCMD);
    for (int i = 0; i < NCMD; i++)
      check(log_code[base+i] == exp_code(i), {"R3 order ", tag}, log_code[base+i], exp_code(i));
    check(done_cnt - dbase == 1, {"R9 single done ", tag}, done_cnt - dbase, 1);
    check(hold_err == hbase, {"R4 hold ", tag}, hold_err - hbase, 0);
    check(feat_err == 0, {"R7 enables ", tag}, feat_err, 0);
    if (ack_mode == 0)
      check(log_cyc[base+1] - log_cyc[base] == WAIT + 1, {"R5 wait ", tag},
            log_cyc[base+1] - log_cyc[base], WAIT + 1);
  endtask

  task automatic t_reset;
    check(!busy_o && !done_o && !cmd_stb_o && cmd_code_o == 3'd0, "R1 control",
          int'({busy_o, done_o, cmd_stb_o, cmd_code_o}), 0);
    check(timing_o == 0 && bank_end_o == 0 && bank_cfg_o == 0, "R1 setup",
          int'({timing_o, bank_end_o, bank_cfg_o}), 0);
    check(!buf_en_o && !ecc_en_o, "R7 reset", int'({buf_en_o, ecc_en_o}), 0);
  endtask

  task automatic t_stall_hold;
    // strobe held without accept: no transfer, code unchanged (R4)
    int base;
    base = nlog;
    @(negedge clk);
    start_i = 1'b1;
    cmd_ack_i = 1'b0;
    @(negedge clk);
    start_i = 1'b0;
    repeat (6) @(negedge clk);
    check(cmd_stb_o && cmd_code_o == 3'd1, "R4 stall hold", int'(cmd_code_o), 1);
    check(nlog == base, "R4 no transfer without accept", nlog - base, 0);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    run_seq(0, 1'b0, "R3 steady accept");
    run_seq(1, 1'b0, "R4 slow accept");
    run_seq(0, 1'b1, "R9 stray start");
    run_seq(0, 1'b0, "R10 rerun");
    t_stall_hold();
    run_seq(1, 1'b1, "R10 after reset");
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule